// File: doc/BRIEF.md
# Recentering Dual-Clock Transmit FIFO

This block sits between a parallel data source clocked by one clock and a serializer that pulls one word per cycle of a second, nominally equal-rate clock. Neither side waits for the other. Every write-clock edge stores the input word and every read-clock edge presents the next stored word, so the FIFO only has to absorb slow phase drift between the two clocks. In normal operation the read pointer trails the write pointer by half the depth.

When the pointers drift so far that the writer would overwrite an unread word, or the reader would fetch a word not yet written, a single sticky fault flag rises. The flag does not say which of the two happened. While the flag is high the output carries a fixed alternating word, so the serial line keeps toggling. The pointers are recentred to half depth whenever the recenter input is high, while the transmit PLL reports loss of lock, and during reset. Each clock domain sees these triggers through its own synchronizer. The fault flag clears once both domains have recentred. Wiring the fault output straight to the recenter input therefore gives automatic recovery.

Top module: `recentering_tx_fifo`

## Requirements
- R1: With both clocks running at the same rate, the words on `dout` are the words taken on `din` in the same order, with no word skipped or repeated.
- R2: While `rst_n` is low, `fault` is 0 and `dout` holds the idle word 16'hAAAA.
- R3: After a recentering trigger is removed, the first six read-clock edges present the idle word: two synchronizer edges, then four reads of the half-depth gap. From the seventh edge on, stored data appears.
- R4: While a recentering trigger (`recenter` high or `pll_lock` low) is applied, `dout` shows the idle word and `fault` stays 0 if no fault was pending.
- R5: Halting the write clock while reads continue (underflow) raises `fault`.
- R6: Halting the read clock while writes continue (overflow) raises `fault` once reads resume.
- R7: `fault` is sticky. It stays high after both clocks run normally again, until a recentering trigger is applied.
- R8: While `fault` is high, `dout` carries the idle word 16'hAAAA instead of FIFO contents.
- R9: `fault` returns to 0 once a recentering trigger (command, loss of lock, or reset) has been seen by both domains.
- R10: With `fault` wired to `recenter`, an underflow is followed by automatic recovery: `fault` falls by itself and the ordered stream resumes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Parallel input clock; one word stored per rising edge |
| rd_clk | input | 1 | Serializer word clock; one word presented per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; also recentres the pointers |
| pll_lock | input | 1 | Transmit PLL lock; low forces recentering |
| recenter | input | 1 | Active-high recenter command, may be tied to `fault` |
| din | input | 16 | Write data, sampled on every `wr_clk` edge |
| dout | output | 16 | Read data or idle word, registered on `rd_clk` |
| fault | output | 1 | Sticky overflow-or-underflow flag, `rd_clk` domain |

## Verification
A pointer out of step with its partner shows up at `dout` within one read cycle as a skipped or repeated word in the counting stream. A wrong centre value shows up as a premature fault, or as stored data appearing one edge early or late after recentering. A stuck or wrongly cleared error state shows at `fault` and at the idle-word substitution a few read cycles after a clock stall or a recenter. The bench therefore drives a counting data pattern, stalls each clock in turn, and counts the idle edges exactly after each release.

// File: rtl/txf_pkg.sv
`timescale 1ns/1ps
package txf_pkg;

   // Read-side sequencing after a recentering trigger is removed.
   typedef enum logic [1:0] {
      RD_HOLD = 2'd0,
      RD_FILL = 2'd1,
      RD_RUN  = 2'd2
   } rd_mode_e;

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/txf_sync.sv
`timescale 1ns/1ps
module txf_sync #(
   parameter int           W       = 1,
   parameter int           STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("txf_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][W-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/txf_store.sv
`timescale 1ns/1ps
module txf_store #(
   parameter int WIDTH = 16,
   parameter int DEPTH = 8
) (
   input  logic                     wr_clk,
   input  logic [$clog2(DEPTH)-1:0] waddr,
   input  logic [WIDTH-1:0]         wdata,
   input  logic [$clog2(DEPTH)-1:0] raddr,
   output logic [WIDTH-1:0]         rdata
);

   logic [WIDTH-1:0] cells [DEPTH];

   // Free running: a word lands on every write edge.
   always_ff @(posedge wr_clk) begin
      cells[waddr] <= wdata;
   end

   assign rdata = cells[raddr];

endmodule

// File: rtl/txf_wr_ctrl.sv
`timescale 1ns/1ps
module txf_wr_ctrl #(
   parameter int DEPTH = 8
) (
   input  logic                   wr_clk,
   input  logic                   rst_n,
   input  logic                   hold_w,
   input  logic [$clog2(DEPTH):0] rgray_s,
   output logic [$clog2(DEPTH)-1:0] waddr,
   output logic [$clog2(DEPTH):0] wgray,
   output logic                   ovf
);

   localparam int AW = $clog2(DEPTH);
   localparam int PW = AW + 1;
   localparam logic [PW-1:0] CENTRE   = PW'(DEPTH / 2);
   localparam logic [PW-1:0] CENTRE_G = CENTRE ^ (CENTRE >> 1);
   localparam logic [PW-1:0] DEPTH_P  = PW'(DEPTH);

   logic [PW-1:0] wptr;
   logic [PW-1:0] wnext;
   logic [PW-1:0] rbin;
   logic [PW-1:0] occ;

   for (genvar i = 0; i < PW; i++) begin : g_rbin
      assign rbin[i] = ^rgray_s[PW-1:i];
   end

   assign wnext = wptr + PW'(1);
   // Seen from here the reader is late, so occupancy is overstated.
   assign occ   = wptr - rbin;
   assign waddr = wptr[AW-1:0];

   always_ff @(posedge wr_clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr  <= CENTRE;
         wgray <= CENTRE_G;
         ovf   <= 1'b0;
      end else if (hold_w) begin
         wptr  <= CENTRE;
         wgray <= CENTRE_G;
         ovf   <= 1'b0;
      end else begin
         wptr  <= wnext;
         wgray <= wnext ^ (wnext >> 1);
         if (occ >= DEPTH_P) ovf <= 1'b1;
      end
   end

   AST_WR_GRAY_STEP: assert property (@(posedge wr_clk) disable iff (!rst_n)
      (!hold_w && $past(!hold_w)) |-> $onehot0(wgray ^ $past(wgray)))
      else $error("write pointer code moved more than one bit"); // R1

   AST_WR_RELEASE: assert property (@(posedge wr_clk) disable iff (!rst_n)
      $fell(hold_w) |-> (wptr == CENTRE))
      else $error("write pointer not centred at release"); // R3

endmodule

// File: rtl/txf_rd_ctrl.sv
`timescale 1ns/1ps
module txf_rd_ctrl
   import txf_pkg::*;
#(
   parameter int               WIDTH     = 16,
   parameter int               DEPTH     = 8,
   parameter logic [WIDTH-1:0] IDLE_WORD = '0
) (
   input  logic                     rd_clk,
   input  logic                     rst_n,
   input  logic                     hold_r,
   input  logic [$clog2(DEPTH):0]   wgray_s,
   input  logic                     ovf_s,
   input  logic [WIDTH-1:0]         rdata,
   output logic [$clog2(DEPTH)-1:0] raddr,
   output logic [$clog2(DEPTH):0]   rgray,
   output logic [WIDTH-1:0]         dout,
   output logic                     fault
);

   localparam int AW = $clog2(DEPTH);
   localparam int PW = AW + 1;
   localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);
   localparam logic [PW-1:0] LAST_GAP = PW'(DEPTH / 2 - 1);

   rd_mode_e      mode, mode_nxt;
   logic [PW-1:0] rptr;
   logic [PW-1:0] rnext;
   logic [PW-1:0] wbin;
   logic [PW-1:0] occ;
   logic          unf_q;
   logic          unf_now;
   logic          fault_nxt;
   logic          idle_sel;

   for (genvar i = 0; i < PW; i++) begin : g_wbin
      assign wbin[i] = ^wgray_s[PW-1:i];
   end

   assign rnext = rptr + PW'(1);
   // Seen from here the writer is late, so occupancy is understated.
   assign occ   = wbin - rptr;
   assign raddr = rptr[AW-1:0];

   assign unf_now   = !hold_r && ((occ == '0) || (occ > DEPTH_P));
   assign fault_nxt = ovf_s || (!hold_r && (unf_q || unf_now));
   assign idle_sel  = hold_r || (mode != RD_RUN) || fault_nxt;

   always_comb begin
      mode_nxt = mode;
      if (hold_r) begin
         mode_nxt = RD_HOLD;
      end else begin
         unique case (mode)
            RD_HOLD, RD_FILL: mode_nxt = (rptr == LAST_GAP) ? RD_RUN : RD_FILL;
            RD_RUN:           mode_nxt = RD_RUN;
            default:          mode_nxt = RD_HOLD;
         endcase
      end
   end

   always_ff @(posedge rd_clk or negedge rst_n) begin
      if (!rst_n) begin
         rptr  <= '0;
         rgray <= '0;
         unf_q <= 1'b0;
         fault <= 1'b0;
         dout  <= IDLE_WORD;
         mode  <= RD_HOLD;
      end else begin
         fault <= fault_nxt;
         dout  <= idle_sel ? IDLE_WORD : rdata;
         mode  <= mode_nxt;
         if (hold_r) begin
            rptr  <= '0;
            rgray <= '0;
            unf_q <= 1'b0;
         end else begin
            rptr  <= rnext;
            rgray <= rnext ^ (rnext >> 1);
            unf_q <= unf_q | unf_now;
         end
      end
   end

   AST_RD_GRAY_STEP: assert property (@(posedge rd_clk) disable iff (!rst_n)
      (!hold_r && $past(!hold_r)) |-> $onehot0(rgray ^ $past(rgray)))
      else $error("read pointer code moved more than one bit"); // R1

   AST_HOLD_IDLE: assert property (@(posedge rd_clk) disable iff (!rst_n)
      hold_r |=> (dout == IDLE_WORD))
      else $error("data leaked during recentering"); // R4

   AST_GAP_IDLE: assert property (@(posedge rd_clk) disable iff (!rst_n)
      $fell(hold_r) |=> (dout == IDLE_WORD))
      else $error("stale word read from the recentre gap"); // R3

   AST_FAULT_IDLE: assert property (@(posedge rd_clk) disable iff (!rst_n)
      fault |-> (dout == IDLE_WORD))
      else $error("data shown while fault is set"); // R8

   AST_FAULT_CLEAR: assert property (@(posedge rd_clk) disable iff (!rst_n)
      $fell(fault) |-> ($past(hold_r) || $past(ovf_s, 2)))
      else $error("fault cleared without recentering"); // R9

endmodule

// File: rtl/recentering_tx_fifo.sv
`timescale 1ns/1ps
module recentering_tx_fifo
   import txf_pkg::*;
#(
   parameter int               WIDTH       = 16,
   parameter int               DEPTH       = 8,
   parameter int               SYNC_STAGES = 2,
   parameter logic [WIDTH-1:0] IDLE_WORD   = {(WIDTH / 2){2'b10}}
) (
   input  logic             wr_clk,
   input  logic             rd_clk,
   input  logic             rst_n,
   input  logic             pll_lock,
   input  logic             recenter,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout,
   output logic             fault
);

   localparam int AW = $clog2(DEPTH);
   localparam int PW = AW + 1;
   localparam logic [PW-1:0] CENTRE   = PW'(DEPTH / 2);
   localparam logic [PW-1:0] CENTRE_G = CENTRE ^ (CENTRE >> 1);

   if (!is_pow2(DEPTH) || DEPTH < 4) begin : g_bad_depth
      $error("recentering_tx_fifo: DEPTH must be a power of two, at least 4");
   end
   if (WIDTH < 2 || (WIDTH % 2) != 0) begin : g_bad_width
      $error("recentering_tx_fifo: WIDTH must be even and at least 2");
   end

   logic          rec_req;
   logic          hold_w, hold_r;
   logic [PW-1:0] wgray, wgray_s;
   logic [PW-1:0] rgray, rgray_s;
   logic          ovf, ovf_s;
   logic [AW-1:0] waddr, raddr;
   logic [WIDTH-1:0] rdata;

   assign rec_req = recenter | ~pll_lock;

   txf_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_hold_w (
      .clk(wr_clk), .rst_n(rst_n), .d(rec_req), .q(hold_w));

   txf_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_hold_r (
      .clk(rd_clk), .rst_n(rst_n), .d(rec_req), .q(hold_r));

   txf_sync #(.W(PW), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_rptr_to_w (
      .clk(wr_clk), .rst_n(rst_n), .d(rgray), .q(rgray_s));

   txf_sync #(.W(PW), .STAGES(SYNC_STAGES), .RST_VAL(CENTRE_G)) u_wptr_to_r (
      .clk(rd_clk), .rst_n(rst_n), .d(wgray), .q(wgray_s));

   txf_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_ovf_to_r (
      .clk(rd_clk), .rst_n(rst_n), .d(ovf), .q(ovf_s));

   txf_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
      .wr_clk(wr_clk), .waddr(waddr), .wdata(din),
      .raddr(raddr), .rdata(rdata));

   txf_wr_ctrl #(.DEPTH(DEPTH)) u_wr (
      .wr_clk(wr_clk), .rst_n(rst_n), .hold_w(hold_w), .rgray_s(rgray_s),
      .waddr(waddr), .wgray(wgray), .ovf(ovf));

   txf_rd_ctrl #(.WIDTH(WIDTH), .DEPTH(DEPTH), .IDLE_WORD(IDLE_WORD)) u_rd (
      .rd_clk(rd_clk), .rst_n(rst_n), .hold_r(hold_r), .wgray_s(wgray_s),
      .ovf_s(ovf_s), .rdata(rdata), .raddr(raddr), .rgray(rgray),
      .dout(dout), .fault(fault));

endmodule

// File: tb/test_recentering_tx_fifo.sv
`timescale 1ns/1ps
module test_recentering_tx_fifo;

   localparam logic [15:0] IDLE = 16'hAAAA;

   logic        wr_clk = 1'b0;
   logic        rd_clk = 1'b0;
   logic        wr_run = 1'b1;
   logic        rd_run = 1'b1;
   logic        rst_n  = 1'b0;
   logic        pll_lock = 1'b1;
   logic        rec_cmd  = 1'b0;
   logic        tie      = 1'b0;
   logic        recenter;
   logic [15:0] din = 16'h0100;
   logic [15:0] dout;
   logic        fault;
   logic        fault_seen = 1'b0;
   int          checks = 0;
   int          errors = 0;

   assign recenter = tie ? fault : rec_cmd;

   recentering_tx_fifo i_recentering_tx_fifo (
      .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .pll_lock(pll_lock),
      .recenter(recenter), .din(din), .dout(dout), .fault(fault));

   // 250 MHz clocks; read edges trail write edges by 1 ns; each can be halted.
   initial forever begin #2; if (wr_run) wr_clk = ~wr_clk; end
   initial begin #1; forever begin #2; if (rd_run) rd_clk = ~rd_clk; end end

   // Counting data, changed away from the write edge.
   initial forever begin @(negedge wr_clk); din = din + 16'd1; end

   initial forever begin @(posedge fault); fault_seen = 1'b1; end

   task automatic chk(input bit ok, input string what, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", what, act, exp);
      end
   endtask

   task automatic rd_wait(input int n);
      repeat (n) @(negedge rd_clk);
   endtask

   // Six idle edges after a trigger is removed, data on the seventh (R3).
   task automatic check_gap(input string tag);
      bit ok = 1'b1;
      logic [15:0] bad = IDLE;
      for (int i = 0; i < 6; i++) begin
         @(negedge rd_clk);
         if (dout !== IDLE) begin ok = 1'b0; bad = dout; end
      end
      chk(ok, {tag, " R3 gap words idle"}, bad, IDLE);
      @(negedge rd_clk);
      chk(dout !== IDLE, {tag, " R3 data on seventh edge"}, dout, 16'h0000);
   endtask

   // Twelve consecutive words, each one more than the last (R1).
   task automatic check_stream(input string tag);
      logic [15:0] prev;
      bit ok = 1'b1;
      logic [15:0] act = 16'h0, exp = 16'h0;
      @(negedge rd_clk);
      prev = dout;
      if (prev === IDLE || fault !== 1'b0) begin ok = 1'b0; act = prev; exp = 16'h0; end
      for (int i = 0; i < 11; i++) begin
         @(negedge rd_clk);
         if (ok && (dout !== prev + 16'd1 || fault !== 1'b0)) begin
            ok = 1'b0; act = dout; exp = prev + 16'd1;
         end
         prev = dout;
      end
      chk(ok, {tag, " R1 ordered stream"}, act, exp);
   endtask

   task automatic t_reset();
      rd_wait(5);
      chk(fault === 1'b0, "R2 fault low in reset", fault, 0);
      chk(dout === IDLE, "R2 idle word in reset", dout, IDLE);
      rst_n = 1'b1;
      check_gap("reset release");
      rd_wait(4);
      check_stream("after reset");
   endtask

   task automatic t_recenter_cmd();
      rec_cmd = 1'b1;
      rd_wait(6);
      chk(dout === IDLE, "R4 idle during recenter", dout, IDLE);
      chk(fault === 1'b0, "R4 no fault during recenter", fault, 0);
      rec_cmd = 1'b0;
      check_gap("command");
      rd_wait(4);
      check_stream("after command");
   endtask

   task automatic t_underflow();
      wr_run = 1'b0;
      rd_wait(10);
      chk(fault === 1'b1, "R5 underflow raises fault", fault, 1);
      chk(dout === IDLE, "R8 idle word under fault", dout, IDLE);
      wr_run = 1'b1;
      rd_wait(20);
      chk(fault === 1'b1, "R7 fault sticky after clocks resume", fault, 1);
      chk(dout === IDLE, "R8 idle word while sticky", dout, IDLE);
      rec_cmd = 1'b1;
      rd_wait(8);
      chk(fault === 1'b0, "R9 command clears fault", fault, 0);
      rec_cmd = 1'b0;
      rd_wait(12);
      check_stream("after underflow");
   endtask

   task automatic t_overflow();
      rd_run = 1'b0;
      repeat (12) @(negedge wr_clk);
      rd_run = 1'b1;
      rd_wait(8);
      chk(fault === 1'b1, "R6 overflow raises fault", fault, 1);
      chk(dout === IDLE, "R8 idle word after overflow", dout, IDLE);
      rst_n = 1'b0;
      #1;
      chk(fault === 1'b0, "R9 reset clears fault", fault, 0);
      rd_wait(3);
      rst_n = 1'b1;
      check_gap("reset after overflow");
      rd_wait(4);
      check_stream("after overflow");
   endtask

   task automatic t_lock_loss();
      wr_run = 1'b0;
      rd_wait(10);
      wr_run = 1'b1;
      rd_wait(4);
      chk(fault === 1'b1, "R5 fault before lock loss", fault, 1);
      pll_lock = 1'b0;
      rd_wait(8);
      chk(fault === 1'b0, "R9 lock loss clears fault", fault, 0);
      chk(dout === IDLE, "R4 idle during lock loss", dout, IDLE);
      pll_lock = 1'b1;
      check_gap("relock");
      rd_wait(4);
      check_stream("after relock");
   endtask

   task automatic t_auto();
      tie = 1'b1;
      fault_seen = 1'b0;
      wr_run = 1'b0;
      rd_wait(10);
      wr_run = 1'b1;
      rd_wait(40);
      chk(fault_seen === 1'b1, "R10 fault occurred in tied mode", fault_seen, 1);
      chk(fault === 1'b0, "R10 fault cleared by itself", fault, 0);
      check_stream("R10 tied recovery");
      tie = 1'b0;
   endtask

   initial begin
      t_reset();
      t_recenter_cmd();
      t_underflow();
      t_overflow();
      t_lock_loss();
      t_auto();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #700000;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule